// File: doc/BRIEF.md
# Configurable Digital Output Routing Unit

This block drives six digital output pins. By default each pin follows one bit of a host-written output control word. Any pin can instead be routed to a single bit of any register in a 254-entry register bank. Each pin has its own routing word, which names the source register and the bit within it. After the routing stage, a polarity mask can invert each pin on its own. A status word returns the exact value sent to the pins. The host reaches all of this through a plain word-wide register bus, with single-cycle writes and combinational reads.

A scanner visits the pins one at a time. For each routed pin it reads the source register through a request/response port and latches the chosen bit. Each pin keeps its last value until the scanner visits it again, so the pins never glitch in the middle of a scan. Two status inputs from the external driver stage are sampled into a read-only word: an overload flag and a supply-detect flag.

The request side of the bank port is valid/ready. Once `rq_valid` is high, it stays high and `rq_reg` stays unchanged until a cycle where `rq_ready` is high. The bank may stall the request for any number of cycles. Only one read is outstanding at a time. The response side has no back-pressure: the block takes `rs_data` in any cycle where `rs_valid` is high, and it never issues a new request while it waits for a response.

Top module: `dout_router`

## Requirements
- R1: After reset, `dout`, the control word, the polarity mask and all six routing words read as zero.
- R2: Address 0 holds the control word. Bit k (k = 0..5) drives pin k when that pin is not routed, and a 1 turns the pin on. Bits 31:6 read as zero.
- R3: Addresses 1 to 6 hold the routing words for pins 0 to 5. Bits [23:16] are the source register number and bits [4:0] are the bit index. All other bits read as zero and ignore writes.
- R4: A source number of 0 or 255 disables routing for that pin, and the pin then follows its control bit.
- R5: A routed pin takes bit `bit index` of the value the bank returns for its source register.
- R6: Address 7 holds the polarity mask. Bit k inverts pin k after the routing stage.
- R7: Address 8 reads the value currently on `dout` in bits [5:0], with zeros above. Writes to it have no effect.
- R8: Address 9 reads the overload input in bit 0 and the supply-detect input in bit 1, each as sampled at the previous clock edge, with zeros above.
- R9: A pending request holds `rq_valid` and `rq_reg` steady until it is accepted. No new request starts before the response arrives.
- R10: Requests are issued only for source numbers 1 to 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 4 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from `hst_addr` |
| rq_valid | output | 1 | Bank read request valid |
| rq_ready | input | 1 | Bank accepts the request |
| rq_reg | output | 8 | Bank register number requested |
| rs_valid | input | 1 | Bank response valid |
| rs_data | input | 32 | Bank response word |
| hw_ovl | input | 1 | Driver overload flag |
| hw_sup | input | 1 | Output supply detected |
| dout | output | 6 | Digital output pins |

## Verification
The bench sweeps every control word against several polarity masks, then runs hundreds of mixed configurations. In these, the six pins point at different registers and bit positions, including register 1, register 254, bit 0 and bit 31, while some pins are disabled with number 0 or 255. If the polarity were applied before the routing stage, routed pins would come out wrong whenever their mask bit is set. If 255 were treated as a valid source, the bank model would log an out-of-range request. The routing words are written with junk in their reserved fields, so a design that stored those bits would read back nonzero. The bank model stalls requests and varies response latency, and it flags any request that drops or changes before acceptance.

// File: rtl/dor_pkg.sv
package dor_pkg;
  localparam int NPIN   = 6;
  localparam int DW     = 32;
  localparam int SRC_W  = 8;
  localparam int BSEL_W = 5;
  localparam int AW     = 4;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_RT0  = 4'd1;
  localparam logic [AW-1:0] A_POL  = 4'd7;
  localparam logic [AW-1:0] A_STAT = 4'd8;
  localparam logic [AW-1:0] A_HW   = 4'd9;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [BSEL_W-1:0] bsel;
  } route_t;

  typedef enum logic [1:0] {S_LOAD, S_REQ, S_WAIT} scan_st_t;
endpackage

// File: rtl/dor_regs.sv
module dor_regs
  import dor_pkg::*;
#(
  parameter int N = NPIN
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [N-1:0]     pin_val,
  input  logic             hw_ovl,
  input  logic             hw_sup,
  output logic [N-1:0]     ctrl,
  output logic [N-1:0]     pol,
  output route_t [N-1:0]   route,
  output logic [DW-1:0]    rdata
);
  logic [1:0] hw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      pol   <= '0;
      route <= '0;
      hw_q  <= '0;
    end else begin
      hw_q <= {hw_sup, hw_ovl};
      if (wr) begin
        if (addr == A_CTRL) ctrl <= wdata[N-1:0];
        if (addr == A_POL)  pol  <= wdata[N-1:0];
        for (int i = 0; i < N; i++) begin
          if (addr == A_RT0 + AW'(i)) begin
            route[i].src  <= wdata[16 +: SRC_W];
            route[i].bsel <= wdata[BSEL_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[N-1:0] = ctrl;
    if (addr == A_POL)  rdata[N-1:0] = pol;
    if (addr == A_STAT) rdata[N-1:0] = pin_val;
    if (addr == A_HW)   rdata[1:0]   = hw_q;
    for (int i = 0; i < N; i++) begin
      if (addr == A_RT0 + AW'(i)) begin
        rdata[16 +: SRC_W]    = route[i].src;
        rdata[BSEL_W-1:0]     = route[i].bsel;
      end
    end
  end
endmodule

// File: rtl/dor_scan.sv
module dor_scan
  import dor_pkg::*;
#(
  parameter int N       = NPIN,
  parameter int SRC_MAX = 254
)(
  input  logic              clk,
  input  logic              rst,
  input  route_t [N-1:0]    route,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [SRC_W-1:0]  rq_reg,
  input  logic              rs_valid,
  input  logic [DW-1:0]     rs_data,
  output logic [N-1:0]      en,
  output logic [N-1:0]      routed
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  scan_st_t      st;
  logic [IW-1:0] idx;
  route_t        cur;
  logic          cur_en;

  function automatic logic in_range(logic [SRC_W-1:0] s);
    return (s != '0) && (s <= SRC_W'(SRC_MAX));
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_en
    assign en[g] = in_range(route[g].src);
  end

  assign cur_en   = in_range(cur.src);
  assign rq_valid = (st == S_REQ) && cur_en;
  assign rq_reg   = cur.src;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_LOAD;
      idx    <= '0;
      cur    <= '0;
      routed <= '0;
    end else begin
      case (st)
        S_LOAD: begin
          cur <= route[idx];
          st  <= S_REQ;
        end
        S_REQ: begin
          if (!cur_en) begin
            idx <= (idx == IW'(N-1)) ? '0 : idx + 1'b1;
            st  <= S_LOAD;
          end else if (rq_ready) begin
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rs_valid) begin
            routed[idx] <= rs_data[cur.bsel];
            idx <= (idx == IW'(N-1)) ? '0 : idx + 1'b1;
            st  <= S_LOAD;
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/dor_out.sv
module dor_out #(
  parameter int N = 6
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ctrl,
  input  logic [N-1:0] en,
  input  logic [N-1:0] routed,
  input  logic [N-1:0] pol,
  output logic [N-1:0] dout
);
  logic [N-1:0] sel;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel[g] = en[g] ? routed[g] : ctrl[g];
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= sel ^ pol;
  end
endmodule

// File: rtl/dout_router.sv
module dout_router
  import dor_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr,
  input  logic [AW-1:0]     hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [SRC_W-1:0]  rq_reg,
  input  logic              rs_valid,
  input  logic [DW-1:0]     rs_data,
  input  logic              hw_ovl,
  input  logic              hw_sup,
  output logic [NPIN-1:0]   dout
);
  logic [NPIN-1:0]  ctrl, pol, en, routed;
  route_t [NPIN-1:0] route;

  dor_regs #(.N(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr(hst_wr), .addr(hst_addr), .wdata(hst_wdata),
    .pin_val(dout), .hw_ovl(hw_ovl), .hw_sup(hw_sup),
    .ctrl(ctrl), .pol(pol), .route(route), .rdata(hst_rdata)
  );

  dor_scan #(.N(NPIN), .SRC_MAX(254)) u_scan (
    .clk(clk), .rst(rst), .route(route),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_reg(rq_reg),
    .rs_valid(rs_valid), .rs_data(rs_data),
    .en(en), .routed(routed)
  );

  dor_out #(.N(NPIN)) u_out (
    .clk(clk), .rst(rst), .ctrl(ctrl), .en(en), .routed(routed),
    .pol(pol), .dout(dout)
  );
endmodule

// File: rtl/dor_chk.sv
module dor_chk
  import dor_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rq_valid,
  input logic             rq_ready,
  input logic [SRC_W-1:0] rq_reg,
  input logic [AW-1:0]    hst_addr,
  input logic [DW-1:0]    hst_rdata,
  input logic             hw_ovl,
  input logic             hw_sup,
  input logic [NPIN-1:0]  dout
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_reg)));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && rq_ready) |=> !rq_valid);

  assert_src_range_R10: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> (rq_reg != 8'd0 && rq_reg != 8'd255));

  assert_status_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    (hst_addr == A_STAT) |-> (hst_rdata == {{(DW-NPIN){1'b0}}, dout}));

  assert_route_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    (hst_addr >= A_RT0 && hst_addr < A_POL) |-> ((hst_rdata & 32'hFF00_FFE0) == '0));

  assert_hw_sample_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hst_addr == A_HW) |->
      (hst_rdata == {{(DW-2){1'b0}}, $past(hw_sup), $past(hw_ovl)}));
endmodule

bind dout_router dor_chk u_chk (
  .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_ready(rq_ready),
  .rq_reg(rq_reg), .hst_addr(hst_addr), .hst_rdata(hst_rdata),
  .hw_ovl(hw_ovl), .hw_sup(hw_sup), .dout(dout)
);

// File: tb/dout_router_test.sv
module dout_router_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        hst_wr = 0;
  logic [3:0]  hst_addr = 0;
  logic [31:0] hst_wdata = 0;
  logic [31:0] hst_rdata;
  logic        rq_valid, rq_ready;
  logic [7:0]  rq_reg;
  logic        rs_valid;
  logic [31:0] rs_data;
  logic        hw_ovl = 0, hw_sup = 0;
  logic [5:0]  dout;

  int checks = 0;
  int fails  = 0;
  int viol   = 0;
  int badsrc = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dout_router uut (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_reg(rq_reg), .rs_valid(rs_valid),
    .rs_data(rs_data), .hw_ovl(hw_ovl), .hw_sup(hw_sup), .dout(dout)
  );

  function automatic logic [31:0] bankval(logic [7:0] n);
    return (32'(n) * 32'h9E37_79B1) ^ {n, 24'h0} ^ 32'h5A5A_0F0F;
  endfunction

  // bank model: stalls requests, varies response latency, watches protocol
  logic [7:0]  tick, paddr, prev_reg;
  logic        pend, prev_v, prev_r;
  logic [1:0]  wcnt;
  always @(posedge clk) begin
    if (rst) begin
      tick <= 0; rq_ready <= 0; rs_valid <= 0; rs_data <= 0;
      pend <= 0; wcnt <= 0; paddr <= 0; prev_v <= 0; prev_r <= 0; prev_reg <= 0;
    end else begin
      tick     <= tick + 1;
      rq_ready <= (tick % 3) != 0;
      rs_valid <= 0;
      if (prev_v && !prev_r && (!rq_valid || rq_reg != prev_reg)) viol <= viol + 1;
      if (rq_valid && pend) viol <= viol + 1;
      if (rq_valid && (rq_reg == 0 || rq_reg == 255)) badsrc <= badsrc + 1;
      prev_v <= rq_valid; prev_r <= rq_ready; prev_reg <= rq_reg;
      if (rq_valid && rq_ready) begin
        pend <= 1; paddr <= rq_reg; wcnt <= tick[2] ? 2'd2 : 2'd0;
      end else if (pend) begin
        if (wcnt == 0) begin
          rs_valid <= 1; rs_data <= bankval(paddr); pend <= 0;
        end else wcnt <= wcnt - 1;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  logic [31:0] rv;
  logic [7:0]  src [6];
  logic [4:0]  bsel[6];

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(32'(dout), 0, "R1 dout");
    for (int a = 0; a < 8; a++) begin
      rd_reg(4'(a), rv);
      check(rv, 0, "R1 register");
    end

    // R2/R6/R7: control word sweep against polarity masks, no routing
    for (int p = 0; p < 4; p++) begin
      logic [5:0] pm;
      pm = (p == 0) ? 6'h00 : (p == 1) ? 6'h3F : (p == 2) ? 6'h15 : 6'h2A;
      wr_reg(4'd7, {26'h3FF_FFFF, pm});
      for (int c = 0; c < 64; c++) begin
        wr_reg(4'd0, 32'hFFFF_FFC0 | 32'(c));
        repeat (2) @(negedge clk);
        check(32'(dout), 32'(6'(c) ^ pm), "R2/R6 pins");
        rd_reg(4'd8, rv);
        check(rv, 32'(6'(c) ^ pm), "R7 status");
      end
      rd_reg(4'd0, rv);
      check(rv, 32'd63, "R2 readback");
    end
    // R7: write to status is ignored
    wr_reg(4'd8, 32'h0000_0000);
    repeat (2) @(negedge clk);
    check(32'(dout), 32'(6'h3F ^ 6'h2A), "R7 write ignored");

    // R3/R4/R5/R6: mixed routing configurations
    for (int t = 0; t < 200; t++) begin
      logic [5:0] cw, pm, exp;
      cw = 6'(t * 5); pm = 6'(t * 3);
      for (int i = 0; i < 6; i++) begin
        if ((t + i) % 5 == 0)  src[i] = ((t >> 1) & 1) ? 8'd255 : 8'd0;
        else if (t % 4 == 0)   src[i] = 8'd254;
        else if (t % 4 == 1)   src[i] = 8'd1;
        else                   src[i] = 8'(1 + ((t * 7 + i * 37) % 254));
        bsel[i] = 5'((t * 3 + i * 11) % 32);
        wr_reg(4'(1 + i), {8'hA5, src[i], 11'h5A3, bsel[i]});
      end
      wr_reg(4'd0, 32'(cw));
      wr_reg(4'd7, 32'(pm));
      repeat (80) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
        logic [31:0] bv;
        bv = bankval(src[i]);
        exp[i] = ((src[i] != 0 && src[i] != 255) ? bv[bsel[i]] : cw[i]) ^ pm[i];
      end
      check(32'(dout), 32'(exp), "R4/R5/R6 routed pins");
      rd_reg(4'(1 + (t % 6)), rv);
      check(rv, {8'h00, src[t % 6], 11'h000, bsel[t % 6]}, "R3 route readback");
    end

    // R8: driver status sampling
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hw_ovl = k[0]; hw_sup = k[1];
      rd_reg(4'd9, rv);
      check(rv, 32'(k), "R8 hw status");
    end
    hw_ovl = 0;
    rd_reg(4'd9, rv);
    check(rv, 32'd2, "R8 overload clears");

    // R9/R10: protocol observations from the bank model
    check(32'(viol), 0, "R9 handshake");
    check(32'(badsrc), 0, "R10 source range");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule